// File: doc/BRIEF.md
# Carry-Save Merged Multiply-Accumulate Unit

This block multiplies two signed operands on each accepted cycle and adds the product to a running total. It is meant for filter and correlation datapaths where a long stream of products is summed. The multiplier operand is recoded into radix-4 signed digits. Each digit selects zero, one or two times the multiplicand, with a negation when the digit is negative. All partial-product rows, their negation corrections, one constant row for sign handling and the previous total meet in a single carry-save reduction tree.

The running total never passes through a carry-propagate adder inside the feedback loop. It is stored as a sum vector and a carry vector. The low bits are resolved early, and the carry out of that low field is kept as one extra bit. A registered final adder, outside the loop, covers only the upper field and forms the visible result.

Controls: `valid_i` together with `en_i` accepts an operand pair. `clr_i` restarts the total, whether or not a pair is accepted on the same cycle.

Top module: `csa_mac`

## Requirements
- R1: Multiplier `a_i` is recoded into OP_W/2 radix-4 digits. Digit i uses bits {a[2i+1], a[2i], a[2i-1]}, with a[-1]=0. The triplets 000/111 select 0, 001/010 select +1, 011 selects +2, 100 selects -2, and 101/110 select -1, each applied to the multiplicand `b_i`.
- R2: A negative digit forms its row as the bitwise inverse of the (OP_W+1)-bit magnitude. The missing +1 enters the tree as a separate correction bit at bit position 2i.
- R3: Each row carries its inverted top bit in place of a replicated sign. All rows share a single constant row, so rows plus corrections plus constant equal a_i*b_i modulo 2^ACC_W.
- R4: The previous total enters the reduction tree as a sum row, a carry row and a one-bit low-field carry row. No separate accumulator adder exists.
- R5: The accumulator registers hold the redundant sum/carry form, and the next accumulation consumes that form directly.
- R6: Before the accumulator registers, the low LOW_W bits are resolved into a single vector plus a carry bit. The final adder spans only the upper ACC_W-LOW_W bits and uses that carry as its carry-in.
- R7: `res_o` equals the two's-complement sum of all accepted products since the last clear, modulo 2^ACC_W.
- R8: A pair is accepted only when `valid_i` and `en_i` are both high. On cycles with no accepted pair and no clear, the total and `res_o` hold their values.
- R9: `clr_i` restarts the total whatever the state of `en_i`. With no accepted pair on that cycle the total becomes 0. With an accepted pair it becomes that product alone.
- R10: `res_vld_o` is high on the third rising edge after the edge that accepts a pair, and only then. `res_o` already reflects that pair at that point.
- R11: While `rst_ni` is low, `res_o` is 0 and `res_vld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair present |
| en_i | input | 1 | Accumulation enable |
| clr_i | input | 1 | Restart the running total |
| a_i | input | OP_W | Signed multiplier (recoded operand) |
| b_i | input | OP_W | Signed multiplicand |
| res_o | output | ACC_W | Resolved running total |
| res_vld_o | output | 1 | Result reflects a newly accepted pair |

## Verification
On every cycle, assertions check three things. The first is that the recoded rows, corrections and constant sum to the true product. The second is that the reduction tree preserves the arithmetic sum of its rows. The third covers the timing relations: the accept-to-valid latency, the idle hold of the redundant registers, and the zeroing on a bare clear. Only the bench's scenarios can show that the resolved total is right. That includes wrap-around modulo 2^ACC_W after many extreme products, a carry crossing the low-field boundary, and each clear and enable combination, all measured against an independent running model at the output.

// File: rtl/csa_mac_pkg.sv
`timescale 1ns/1ps
package csa_mac_pkg;

  typedef enum logic [1:0] {
    BSEL_ZERO = 2'd0,
    BSEL_ONE  = 2'd1,
    BSEL_TWO  = 2'd2
  } bsel_e;

  typedef struct packed {
    bsel_e sel;
    logic  neg;
  } booth_dig_t;

  // radix-4 digit from {hi, mid, lo} multiplier bits
  function automatic booth_dig_t booth_decode(input logic [2:0] trip);
    booth_dig_t d;
    unique case (trip)
      3'b001, 3'b010: d = '{sel: BSEL_ONE,  neg: 1'b0};
      3'b011:         d = '{sel: BSEL_TWO,  neg: 1'b0};
      3'b100:         d = '{sel: BSEL_TWO,  neg: 1'b1};
      3'b101, 3'b110: d = '{sel: BSEL_ONE,  neg: 1'b1};
      default:        d = '{sel: BSEL_ZERO, neg: 1'b0};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/csa_mac_booth.sv
`timescale 1ns/1ps
module csa_mac_booth
  import csa_mac_pkg::*;
#(
  parameter int unsigned OP_W  = 16,
  parameter int unsigned ACC_W = 40
) (
  input  logic [OP_W-1:0]                 mplier_i,
  input  logic [OP_W-1:0]                 mcand_i,
  output logic [OP_W/2-1:0][ACC_W-1:0]    rows_o,
  output logic [ACC_W-1:0]                corr_o,
  output logic [ACC_W-1:0]                sfix_o
);
  localparam int unsigned N_PP = OP_W / 2;
  localparam int unsigned PP_W = OP_W + 1;

  function automatic logic [ACC_W-1:0] sign_fix();
    logic [ACC_W-1:0] s;
    s = '0;
    for (int i = 0; i < int'(N_PP); i++) s = s + (ACC_W'(1) << (PP_W - 1 + 2 * i));
    return -s;
  endfunction

  localparam logic [ACC_W-1:0] SIGN_FIX = sign_fix();

  logic [N_PP-1:0] neg_w;

  for (genvar i = 0; i < int'(N_PP); i++) begin : g_row
    logic [2:0]      trip;
    booth_dig_t      dig;
    logic [PP_W-1:0] mag, raw, ext;

    if (i == 0) begin : g_first
      assign trip = {mplier_i[1:0], 1'b0};
    end else begin : g_rest
      assign trip = mplier_i[2*i+1 : 2*i-1];
    end

    assign dig = booth_decode(trip);

    always_comb begin
      unique case (dig.sel)
        BSEL_ONE: mag = {mcand_i[OP_W-1], mcand_i};
        BSEL_TWO: mag = {mcand_i, 1'b0};
        default:  mag = '0;
      endcase
    end

    assign raw        = dig.neg ? ~mag : mag;   // one's complement only
    assign ext        = {~raw[PP_W-1], raw[PP_W-2:0]};
    assign rows_o[i]  = ACC_W'(ext) << (2 * i);
    assign neg_w[i]   = dig.neg;
  end

  always_comb begin
    corr_o = '0;
    for (int i = 0; i < int'(N_PP); i++) corr_o[2*i] = neg_w[i];
  end

  assign sfix_o = SIGN_FIX;

  // checker: rows + corrections + constant == exact product
  logic [ACC_W-1:0] chk_sum, chk_prod;
  always_comb begin
    chk_sum = corr_o + sfix_o;
    for (int i = 0; i < int'(N_PP); i++) chk_sum = chk_sum + rows_o[i];
    chk_prod = {{(ACC_W-OP_W){mplier_i[OP_W-1]}}, mplier_i} *
               {{(ACC_W-OP_W){mcand_i[OP_W-1]}}, mcand_i};
    AST_BOOTH_SUM: assert (chk_sum == chk_prod); // R1 R2 R3
  end

endmodule

// File: rtl/csa_mac_tree.sv
`timescale 1ns/1ps
module csa_mac_tree #(
  parameter int unsigned N_IN = 13,
  parameter int unsigned W    = 40
) (
  input  logic [N_IN-1:0][W-1:0] rows_i,
  output logic [W-1:0]           sum_o,
  output logic [W-1:0]           carry_o
);
  logic [W-1:0] cur [N_IN+2];
  logic [W-1:0] nxt [N_IN+2];
  int n, m;

  // 3:2 compressor levels until two rows remain
  always_comb begin
    cur = '{default: '0};
    nxt = '{default: '0};
    for (int k = 0; k < int'(N_IN); k++) cur[k] = rows_i[k];
    n = int'(N_IN);
    m = 0;
    for (int l = 0; l < int'(N_IN); l++) begin
      if (n > 2) begin
        m   = 0;
        nxt = '{default: '0};
        for (int j = 0; j < int'(N_IN); j += 3) begin
          if (j + 2 < n) begin
            nxt[m]   = cur[j] ^ cur[j+1] ^ cur[j+2];
            nxt[m+1] = ((cur[j] & cur[j+1]) | (cur[j] & cur[j+2]) |
                        (cur[j+1] & cur[j+2])) << 1;
            m = m + 2;
          end else if (j < n) begin
            nxt[m] = cur[j];
            m = m + 1;
            if (j + 1 < n) begin
              nxt[m] = cur[j+1];
              m = m + 1;
            end
          end
        end
        cur = nxt;
        n   = m;
      end
    end
    sum_o   = cur[0];
    carry_o = (n > 1) ? cur[1] : '0;
  end

  logic [W-1:0] chk_in;
  always_comb begin
    chk_in = '0;
    for (int k = 0; k < int'(N_IN); k++) chk_in = chk_in + rows_i[k];
    AST_TREE_SUM: assert (W'(sum_o + carry_o) == chk_in); // R4
  end

endmodule

// File: rtl/csa_mac_final.sv
`timescale 1ns/1ps
module csa_mac_final #(
  parameter int unsigned ACC_W = 40,
  parameter int unsigned LOW_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ACC_W-1:0]       s_i,
  input  logic [ACC_W-LOW_W-1:0] c_hi_i,
  input  logic                   cy_i,
  input  logic                   vld_i,
  output logic [ACC_W-1:0]       res_o,
  output logic                   res_vld_o
);
  localparam int unsigned HI_W = ACC_W - LOW_W;

  logic [HI_W-1:0] hi_sum;
  assign hi_sum = s_i[ACC_W-1:LOW_W] + c_hi_i + HI_W'(cy_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      res_vld_o <= 1'b0;
    end else begin
      res_o     <= {hi_sum, s_i[LOW_W-1:0]};
      res_vld_o <= vld_i;
    end
  end

endmodule

// File: rtl/csa_mac.sv
`timescale 1ns/1ps
module csa_mac #(
  parameter int unsigned OP_W  = 16,
  parameter int unsigned ACC_W = 40,
  parameter int unsigned LOW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  output logic [ACC_W-1:0] res_o,
  output logic             res_vld_o
);
  localparam int unsigned N_PP   = OP_W / 2;
  localparam int unsigned N_ROWS = N_PP + 5;
  localparam int unsigned HI_W   = ACC_W - LOW_W;

  // stage 0: operand capture
  logic            in_vld_q, in_clr_q;
  logic [OP_W-1:0] a_q, b_q;
  logic            take;
  assign take = valid_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_vld_q <= 1'b0;
      in_clr_q <= 1'b0;
      a_q      <= '0;
      b_q      <= '0;
    end else begin
      in_vld_q <= take;
      in_clr_q <= clr_i;
      if (take) begin
        a_q <= a_i;
        b_q <= b_i;
      end
    end
  end

  // stage 1: recoding, merged tree, redundant accumulator
  logic [N_PP-1:0][ACC_W-1:0] pp_rows;
  logic [ACC_W-1:0]           corr, sfix;

  csa_mac_booth #(.OP_W(OP_W), .ACC_W(ACC_W)) u_booth (
    .mplier_i (a_q),
    .mcand_i  (b_q),
    .rows_o   (pp_rows),
    .corr_o   (corr),
    .sfix_o   (sfix)
  );

  logic [ACC_W-1:0] acc_s_q;
  logic [HI_W-1:0]  acc_c_q;
  logic             acc_cy_q;
  logic             acc_vld_q;

  logic [ACC_W-1:0] fb_s, fb_c, fb_cy;
  assign fb_s  = in_clr_q ? '0 : acc_s_q;
  assign fb_c  = in_clr_q ? '0 : {acc_c_q, {LOW_W{1'b0}}};
  assign fb_cy = in_clr_q ? '0 : (ACC_W'(acc_cy_q) << LOW_W);

  logic [N_ROWS-1:0][ACC_W-1:0] tree_rows;
  assign tree_rows = {pp_rows, corr, sfix, fb_s, fb_c, fb_cy};

  logic [ACC_W-1:0] t_sum, t_carry;

  csa_mac_tree #(.N_IN(N_ROWS), .W(ACC_W)) u_tree (
    .rows_i  (tree_rows),
    .sum_o   (t_sum),
    .carry_o (t_carry)
  );

  logic [LOW_W:0] lo_res;
  assign lo_res = {1'b0, t_sum[LOW_W-1:0]} + {1'b0, t_carry[LOW_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_s_q   <= '0;
      acc_c_q   <= '0;
      acc_cy_q  <= 1'b0;
      acc_vld_q <= 1'b0;
    end else begin
      acc_vld_q <= in_vld_q;
      if (in_vld_q) begin
        acc_s_q  <= {t_sum[ACC_W-1:LOW_W], lo_res[LOW_W-1:0]};
        acc_c_q  <= t_carry[ACC_W-1:LOW_W];
        acc_cy_q <= lo_res[LOW_W];
      end else if (in_clr_q) begin
        acc_s_q  <= '0;
        acc_c_q  <= '0;
        acc_cy_q <= 1'b0;
      end
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_vld_q && !in_clr_q) |=> ($stable(acc_s_q) && $stable(acc_c_q) && $stable(acc_cy_q))); // R8

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_clr_q && !in_vld_q) |=> (acc_s_q == '0 && acc_c_q == '0 && !acc_cy_q)); // R9

  // stage 2: upper-field carry-propagate adder
  csa_mac_final #(.ACC_W(ACC_W), .LOW_W(LOW_W)) u_final (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .s_i       (acc_s_q),
    .c_hi_i    (acc_c_q),
    .cy_i      (acc_cy_q),
    .vld_i     (acc_vld_q),
    .res_o     (res_o),
    .res_vld_o (res_vld_o)
  );

  AST_ACCEPT_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && en_i) |-> ##3 res_vld_o); // R10

  AST_NO_SPURIOUS_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && en_i) |-> ##3 !res_vld_o); // R8

endmodule

// File: tb/csa_mac_bench.sv
`timescale 1ns/1ps
module csa_mac_bench;
  localparam int unsigned OP_W  = 16;
  localparam int unsigned ACC_W = 40;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             valid_i = 1'b0, en_i = 1'b0, clr_i = 1'b0;
  logic [OP_W-1:0]  a_i = '0, b_i = '0;
  logic [ACC_W-1:0] res_o;
  logic             res_vld_o;

  always #10 clk_i = ~clk_i;

  csa_mac #(.OP_W(OP_W), .ACC_W(ACC_W), .LOW_W(8)) u_csa_mac (
    .clk_i, .rst_ni, .valid_i, .en_i, .clr_i, .a_i, .b_i, .res_o, .res_vld_o
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [ACC_W-1:0] m_acc = '0;
  logic [ACC_W-1:0] pr [3] = '{default: '0};
  logic             pv [3] = '{default: 1'b0};
  logic [31:0]      lfsr = 32'h1234_5678;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one clock: drive, advance model, check outputs three edges behind
  task automatic cyc(input string req, input logic v, input logic en, input logic clr,
                     input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
    logic signed [31:0] p;
    valid_i = v; en_i = en; clr_i = clr; a_i = a; b_i = b;
    p = $signed(a) * $signed(b);
    if (clr) m_acc = (v && en) ? {{8{p[31]}}, p} : '0;
    else if (v && en) m_acc = m_acc + {{8{p[31]}}, p};
    @(negedge clk_i);
    pv[2] = pv[1]; pv[1] = pv[0]; pv[0] = v && en;
    pr[2] = pr[1]; pr[1] = pr[0]; pr[0] = m_acc;
    chk(req, 64'(res_vld_o), 64'(pv[2]));
    chk(req, 64'(res_o), 64'(pr[2]));
  endtask

  task automatic idle(input string req, input int n);
    for (int i = 0; i < n; i++) cyc(req, 1'b0, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    chk("R11", 64'(res_o), 64'd0);
    chk("R11", 64'(res_vld_o), 64'd0);
    rst_ni = 1'b1;
    idle("R11", 2);
  endtask

  task automatic t_basic();
    cyc("R7 R1", 1, 1, 1, 16'd3, 16'd5);
    cyc("R7 R2", 1, 1, 0, -16'sd7, 16'd4);
    cyc("R7 R3", 1, 1, 0, 16'd6, -16'sd9);
    cyc("R7 R2", 1, 1, 0, -16'sd1, -16'sd1);
    idle("R7", 3);
  endtask

  task automatic t_extremes();
    cyc("R1 R3", 1, 1, 1, 16'h8000, 16'h8000);
    cyc("R2 R3", 1, 1, 0, 16'h7FFF, 16'h8000);
    cyc("R1 R2", 1, 1, 0, 16'h8000, 16'h7FFF);
    cyc("R1 R3", 1, 1, 0, 16'h7FFF, 16'h7FFF);
    cyc("R2", 1, 1, 0, 16'hAAAA, 16'h5555);
    cyc("R1", 1, 1, 0, 16'h0000, 16'h8000);
    idle("R3", 3);
  endtask

  task automatic t_low_carry();
    cyc("R6", 1, 1, 1, 16'd255, 16'd1);
    cyc("R6", 1, 1, 0, 16'd1, 16'd1);
    cyc("R6", 1, 1, 0, -16'sd1, 16'd1);
    cyc("R6", 1, 1, 0, -16'sd1, 16'd255);
    cyc("R6", 1, 1, 0, -16'sd1, 16'd1);
    idle("R6", 3);
  endtask

  task automatic t_hold();
    cyc("R8", 1, 1, 1, 16'd100, 16'd7);
    cyc("R8", 1, 0, 0, 16'd1234, 16'd99);
    cyc("R8", 0, 1, 0, 16'd555, 16'd3);
    cyc("R8", 1, 0, 0, 16'h8000, 16'h8000);
    idle("R8", 3);
    cyc("R8", 1, 1, 0, 16'd2, 16'd2);
    idle("R8", 3);
  endtask

  task automatic t_clear();
    cyc("R9", 1, 1, 1, 16'd40, 16'd40);
    idle("R9", 3);
    cyc("R9", 0, 0, 1, '0, '0);
    idle("R9", 3);
    cyc("R9", 1, 1, 0, 16'd11, 16'd13);
    cyc("R9", 1, 0, 1, 16'd77, 16'd77);
    idle("R9", 3);
    cyc("R9", 1, 1, 0, 16'd5, 16'd5);
    cyc("R9", 1, 1, 1, -16'sd300, 16'd21);
    cyc("R9", 1, 1, 0, 16'd1, 16'd1);
    idle("R9", 3);
  endtask

  task automatic t_latency();
    idle("R10", 4);
    cyc("R10", 1, 1, 0, 16'd9, 16'd9);
    idle("R10", 5);
    cyc("R10", 1, 1, 0, 16'd1, 16'd2);
    cyc("R10", 0, 1, 0, 16'd1, 16'd2);
    cyc("R10", 1, 1, 0, 16'd3, 16'd4);
    idle("R10", 4);
  endtask

  task automatic t_random();
    cyc("R7", 1, 1, 1, 16'd0, 16'd0);
    for (int i = 0; i < 300; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      cyc("R7 R4 R5", lfsr[0] | lfsr[1], lfsr[2] | lfsr[3], lfsr[4] & lfsr[5] & lfsr[6],
          lfsr[31:16], lfsr[23:8]);
    end
    idle("R7", 3);
  endtask

  task automatic t_wrap();
    cyc("R7", 1, 1, 1, 16'h8000, 16'h8000);
    for (int i = 1; i < 1100; i++) cyc("R7", 1, 1, 0, 16'h8000, 16'h8000);
    idle("R7", 3);
    chk("R7", 64'(res_o), 64'(40'd76 << 30));
  endtask

  initial begin
    t_reset();
    t_basic();
    t_extremes();
    t_low_carry();
    t_hold();
    t_clear();
    t_latency();
    t_random();
    t_wrap();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
    $finish;
  end

endmodule